// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Read Path

This block is the load side of a 16 KB first-level data cache. The cache has 128 sets of four 32-byte lines. A load arrives with its untranslated 32-bit address. The set is picked from address bits that lie inside the 12-bit page offset, so the four tags and lines of that set are read in the request cycle, while the translation unit is still working. One cycle later the translation unit supplies the physical page number. The tag compare runs against that number in the same cycle, and the block returns either the addressed 32-bit word with a hit flag or a miss.

On a miss the block raises a line request to the next level, carrying the full physical address. It refuses new loads until the line comes back through the fill port. The fill writes the line into an invalid way, or else into the way named by a per-set round-robin pointer. The block then replays the missed load internally and returns the word as a hit.

Top module: `vipt_l1_read`

## Requirements
- R1: The cache is organised as 128 sets × 4 ways × 32-byte lines. The byte offset is address bits 4:0, the set index is bits 11:5 of the virtual address, and the stored tag is the 20-bit physical page number (physical address bits 31:12).
- R2: When a load is accepted (`req_valid` and `req_ready` high at a clock edge), `rsp_valid` is high in the next cycle. `rsp_hit` is high in that cycle when a valid way of the selected set holds a tag equal to the `xlat_ppn` presented in that cycle. On a hit, `rsp_data` is line word number `vaddr[4:2]`, taken from line bits 32·w+31 down to 32·w.
- R3: The set is chosen only from the page-offset bits. Two virtual addresses that differ in bits 31:12 but translate to the same physical page find the same line.
- R4: Byte-offset bits 1:0 do not affect which word is returned.
- R5: A load whose compare fails gives `rsp_valid`=1 with `rsp_hit`=0. In the next cycle `miss_req_valid` rises with `miss_req_addr` = {physical page number, vaddr[11:0]}. Both are held until `fill_valid` is seen.
- R6: `req_ready` is low from the miss-compare cycle until the replayed load has been re-read. It is high again in the cycle in which the replayed hit is reported.
- R7: A fill accepted while a miss is outstanding writes `fill_line` into the missed set with a valid bit and the missed tag. Two cycles after that edge, `rsp_valid` and `rsp_hit` are high with the requested word.
- R8: The way chosen for a fill is the lowest-numbered invalid way. When all four ways are valid, the victim is the set's round-robin pointer, which starts at way 0 and advances by one after each such eviction.
- R9: Reset (`rst_n` low) clears every valid bit and the control state. While in reset, `req_ready`=1, `rsp_valid`=0 and `miss_req_valid`=0. After reset, every earlier line misses.
- R10: `fill_valid` pulsed while no miss is outstanding changes no line and raises no request.
- R11: A load whose physical page number differs from every stored tag of its set misses, even if the same virtual address hit before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a load this cycle |
| req_vaddr | input | 32 | Untranslated load address |
| xlat_ppn | input | 20 | Physical page number, valid the cycle after acceptance |
| rsp_valid | output | 1 | Tag-compare result available |
| rsp_hit | output | 1 | Compare found a matching valid line |
| rsp_data | output | 32 | Addressed word on a hit |
| miss_req_valid | output | 1 | Line request to the next level outstanding |
| miss_req_addr | output | 32 | Physical address of the missed load |
| fill_valid | input | 1 | Returned line present |
| fill_line | input | 256 | Returned 32-byte line, word w in bits 32w+31:32w |

## Verification
The main lookup is first driven through a table of loads. The table mixes cold misses, repeat hits, different words of the same line, and a second virtual page that aliases the same physical page. It also includes a load whose page number changes under an unchanged virtual address and a load with nonzero low byte-offset bits. Together these separate a physical tag from a virtual one, show that the index comes from the page offset, and show that word selection ignores bits 1:0. A directed run fills one set past its four ways and follows the evictions step by step, which tells invalid-first choice apart from round-robin replacement. Further directed runs cover a fill pulse with no miss outstanding, reset during traffic, and the `req_ready` hold-off while a miss is outstanding.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned CFG_ADDR_W     = 32;
  localparam int unsigned CFG_PAGE_W     = 12;
  localparam int unsigned CFG_LINE_BYTES = 32;
  localparam int unsigned CFG_SETS       = 128;
  localparam int unsigned CFG_WAYS       = 4;
  localparam int unsigned CFG_WORD_W     = 32;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REPLAY = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/vipt_set_store.sv
module vipt_set_store #(
  parameter int unsigned SETS   = vipt_pkg::CFG_SETS,
  parameter int unsigned WAYS   = vipt_pkg::CFG_WAYS,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned LINE_W = 256,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
  output logic [WAYS-1:0]                   rd_vld,
  output logic [WAYS-1:0][LINE_W-1:0]       rd_line,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic [LINE_W-1:0]                 wr_line
);
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] line_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [PTR_W-1:0]  rr_q   [SETS];

  logic [PTR_W-1:0]  victim;
  logic              evict;

  // Lowest invalid way wins; a full set falls back on its pointer.
  always_comb begin
    victim = rr_q[wr_idx];
    evict  = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[wr_idx][w]) begin
        victim = PTR_W'(w);
        evict  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_idx][victim] <= 1'b1;
      if (evict) rr_q[wr_idx] <= rr_q[wr_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx][victim]  <= wr_tag;
      line_q[wr_idx][victim] <= wr_line;
    end
  end

  // Whole set is read into registers in the request cycle.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        rd_tag[w]  <= tag_q[rd_idx][w];
        rd_line[w] <= line_q[rd_idx][w];
        rd_vld[w]  <= vld_q[rd_idx][w];
      end
    end
  end
endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
  parameter int unsigned WAYS   = vipt_pkg::CFG_WAYS,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned LINE_W = 256,
  parameter int unsigned WORD_W = vipt_pkg::CFG_WORD_W,
  localparam int unsigned WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
  input  logic [WAYS-1:0]             set_vld,
  input  logic [WAYS-1:0][LINE_W-1:0] set_line,
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic [WSEL_W-1:0]           word_sel,
  output logic                        hit,
  output logic [WORD_W-1:0]           word
);
  logic [WAYS-1:0]             way_hit;
  logic [WAYS-1:0][WORD_W-1:0] way_word;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w]  = set_vld[w] && (set_tag[w] == cmp_tag);
    assign way_word[w] = set_line[w][word_sel*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) word = word | way_word[w];
    end
  end

  assign hit = |way_hit;
endmodule

// File: rtl/vipt_l1_read.sv
module vipt_l1_read #(
  parameter int unsigned ADDR_W     = vipt_pkg::CFG_ADDR_W,
  parameter int unsigned PAGE_W     = vipt_pkg::CFG_PAGE_W,
  parameter int unsigned LINE_BYTES = vipt_pkg::CFG_LINE_BYTES,
  parameter int unsigned NUM_SETS   = vipt_pkg::CFG_SETS,
  parameter int unsigned NUM_WAYS   = vipt_pkg::CFG_WAYS,
  parameter int unsigned WORD_W     = vipt_pkg::CFG_WORD_W,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W     = $clog2(NUM_SETS),
  localparam int unsigned TAG_W     = ADDR_W - PAGE_W,
  localparam int unsigned LINE_W    = LINE_BYTES * 8,
  localparam int unsigned BSEL_W    = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [TAG_W-1:0]  xlat_ppn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_data,
  output logic              miss_req_valid,
  output logic [ADDR_W-1:0] miss_req_addr,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line
);
  import vipt_pkg::*;

  ctl_state_e          state_q, state_d;
  logic                s1_vld_q, s1_vld_d;
  logic                s1_rep_q, s1_rep_d;
  logic [PAGE_W-1:0]   s1_off_q, s1_off_d;
  logic [ADDR_W-1:0]   miss_q, miss_d;

  logic                rd_en;
  logic [IDX_W-1:0]    rd_idx;
  logic [NUM_WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [NUM_WAYS-1:0]             set_vld;
  logic [NUM_WAYS-1:0][LINE_W-1:0] set_line;
  logic [TAG_W-1:0]    cmp_tag;
  logic                tag_hit;
  logic [WORD_W-1:0]   sel_word;
  logic                s1_miss;
  logic                fill_en;
  logic                unused_vpn_bits;

  assign unused_vpn_bits = ^req_vaddr[ADDR_W-1:PAGE_W];

  // Compare stage: the page number comes from the translation unit,
  // or from the saved miss address when the load is a replay.
  assign cmp_tag   = s1_rep_q ? miss_q[ADDR_W-1:PAGE_W] : xlat_ppn;
  assign s1_miss   = s1_vld_q && !tag_hit;
  assign req_ready = (state_q == ST_RUN) && !s1_miss;

  always_comb begin
    rd_en    = (state_q == ST_REPLAY) || (req_valid && req_ready);
    s1_vld_d = rd_en;
    s1_rep_d = (state_q == ST_REPLAY);
    s1_off_d = s1_rep_d ? miss_q[PAGE_W-1:0] : req_vaddr[PAGE_W-1:0];
    rd_idx   = s1_off_d[OFF_W +: IDX_W];
  end

  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    fill_en = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (s1_miss) begin
          state_d = ST_WAIT;
          miss_d  = {cmp_tag, s1_off_q};
        end
      end
      ST_WAIT: begin
        if (fill_valid) begin
          fill_en = 1'b1;
          state_d = ST_REPLAY;
        end
      end
      ST_REPLAY: state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      s1_vld_q <= 1'b0;
      s1_rep_q <= 1'b0;
      s1_off_q <= '0;
      miss_q   <= '0;
    end else begin
      state_q  <= state_d;
      s1_vld_q <= s1_vld_d;
      if (rd_en) begin
        s1_rep_q <= s1_rep_d;
        s1_off_q <= s1_off_d;
      end
      if (s1_miss && state_q == ST_RUN) miss_q <= miss_d;
    end
  end

  vipt_set_store #(
    .SETS   (NUM_SETS),
    .WAYS   (NUM_WAYS),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W)
  ) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_tag  (set_tag),
    .rd_vld  (set_vld),
    .rd_line (set_line),
    .wr_en   (fill_en),
    .wr_idx  (miss_q[OFF_W +: IDX_W]),
    .wr_tag  (miss_q[ADDR_W-1:PAGE_W]),
    .wr_line (fill_line)
  );

  vipt_tag_match #(
    .WAYS   (NUM_WAYS),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W),
    .WORD_W (WORD_W)
  ) i_match (
    .set_tag  (set_tag),
    .set_vld  (set_vld),
    .set_line (set_line),
    .cmp_tag  (cmp_tag),
    .word_sel (s1_off_q[OFF_W-1:BSEL_W]),
    .hit      (tag_hit),
    .word     (sel_word)
  );

  assign rsp_valid      = s1_vld_q;
  assign rsp_hit        = s1_vld_q && tag_hit;
  assign rsp_data       = rsp_hit ? sel_word : '0;
  assign miss_req_valid = (state_q == ST_WAIT);
  assign miss_req_addr  = miss_q;
endmodule

// File: rtl/vipt_l1_chk.sv
module vipt_l1_chk #(
  parameter int unsigned ADDR_W = vipt_pkg::CFG_ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              miss_req_valid,
  input logic [ADDR_W-1:0] miss_req_addr,
  input logic              fill_valid
);
  // R2
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R5
  miss_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |=> miss_req_valid);

  // R5
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req_valid && !fill_valid) |=> (miss_req_valid && $stable(miss_req_addr)));

  // R6
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req_valid |-> !req_ready);

  // R7
  replay_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req_valid && fill_valid) |-> ##2 (rsp_valid && rsp_hit));
endmodule

bind vipt_l1_read vipt_l1_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .miss_req_valid (miss_req_valid),
  .miss_req_addr  (miss_req_addr),
  .fill_valid     (fill_valid)
);

// File: tb/test_vipt_l1_read.sv
module test_vipt_l1_read;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_vaddr;
  logic [19:0]  xlat_ppn;
  logic         rsp_valid;
  logic         rsp_hit;
  logic [31:0]  rsp_data;
  logic         miss_req_valid;
  logic [31:0]  miss_req_addr;
  logic         fill_valid;
  logic [255:0] fill_line;

  int checks;
  int failures;
  bit done;

  vipt_l1_read i_vipt_l1_read (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .xlat_ppn       (xlat_ppn),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_data       (rsp_data),
    .miss_req_valid (miss_req_valid),
    .miss_req_addr  (miss_req_addr),
    .fill_valid     (fill_valid),
    .fill_line      (fill_line)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {expected hit, ppn, vaddr}
  localparam int NVEC = 8;
  localparam logic [52:0] VEC [NVEC] = '{
    {1'b0, 20'h12345, 32'h0000_1040},  // cold miss, set 2
    {1'b1, 20'h12345, 32'h0000_1040},  // repeat hit
    {1'b1, 20'h12345, 32'h0000_105C},  // word 7 of same line
    {1'b1, 20'h12345, 32'h0000_2040},  // other VPN, same physical page
    {1'b0, 20'h0ABCD, 32'h0000_1040},  // same VA, other physical page
    {1'b1, 20'h12345, 32'h0000_1043},  // low offset bits set
    {1'b0, 20'h00077, 32'h0000_1FE0},  // last set
    {1'b1, 20'h00077, 32'h0000_1FE0}
  };

  function automatic logic [31:0] exp_word(input logic [19:0] ppn, input logic [31:0] va);
    return {ppn[11:0], va[11:5], va[4:2], 10'h2A5};
  endfunction

  function automatic logic [255:0] make_line(input logic [19:0] ppn, input logic [31:0] va);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = {ppn[11:0], va[11:5], 3'(w), 10'h2A5};
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One load; on a miss, serve the line request and check the replay.
  task automatic do_load(input logic [31:0] va, input logic [19:0] ppn,
                         input bit exp_hit, input string req);
    @(negedge clk);
    check(req_ready == 1'b1, "R6 ready before load", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    xlat_ppn  = ppn;
    #1;
    check(rsp_valid == 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_hit == exp_hit, req, 64'(rsp_hit), 64'(exp_hit));
    if (rsp_hit) begin
      check(rsp_data == exp_word(ppn, va), "R2 hit data", 64'(rsp_data), 64'(exp_word(ppn, va)));
    end else begin
      @(negedge clk);
      check(miss_req_valid == 1'b1, "R5 miss request", 64'(miss_req_valid), 64'd1);
      check(miss_req_addr == {ppn, va[11:0]}, "R5 miss address", 64'(miss_req_addr), 64'({ppn, va[11:0]}));
      check(req_ready == 1'b0, "R6 ready low in wait", 64'(req_ready), 64'd0);
      fill_valid = 1'b1;
      fill_line  = make_line(ppn, va);
      @(negedge clk);
      fill_valid = 1'b0;
      fill_line  = '0;
      check(req_ready == 1'b0, "R6 ready low in replay", 64'(req_ready), 64'd0);
      check(miss_req_valid == 1'b0, "R5 request dropped after fill", 64'(miss_req_valid), 64'd0);
      @(negedge clk);
      #1;
      check(rsp_valid && rsp_hit, "R7 replay hit", 64'({rsp_valid, rsp_hit}), 64'd3);
      check(rsp_data == exp_word(ppn, va), "R7 replay data", 64'(rsp_data), 64'(exp_word(ppn, va)));
      check(req_ready == 1'b1, "R6 ready after replay", 64'(req_ready), 64'd1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; xlat_ppn = '0;
    fill_valid = 1'b0; fill_line = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 ready in reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check(miss_req_valid == 1'b0, "R9 miss idle in reset", 64'(miss_req_valid), 64'd0);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R4 R11
    for (int i = 0; i < NVEC; i++) begin
      do_load(VEC[i][31:0], VEC[i][51:32], VEC[i][52], $sformatf("R1 R3 R4 R11 vector %0d hit", i));
    end

    // R10: stray fill while idle
    @(negedge clk);
    fill_valid = 1'b1;
    fill_line  = {256{1'b1}};
    @(negedge clk);
    fill_valid = 1'b0;
    fill_line  = '0;
    check(miss_req_valid == 1'b0, "R10 no request from stray fill", 64'(miss_req_valid), 64'd0);
    check(rsp_valid == 1'b0, "R10 no response from stray fill", 64'(rsp_valid), 64'd0);
    do_load(32'h0000_1040, 20'h12345, 1'b1, "R10 line intact after stray fill");
    do_load(32'h0000_1040, 20'h0ABCD, 1'b1, "R10 second way intact");
    do_load(32'h0000_1FE0, 20'h00077, 1'b1, "R10 set 127 intact");

    // R8: fill set 5 past its four ways
    do_load(32'h0000_00A0, 20'h00100, 1'b0, "R8 way0 fill");
    do_load(32'h0000_00A0, 20'h00200, 1'b0, "R8 way1 fill");
    do_load(32'h0000_00A0, 20'h00300, 1'b0, "R8 way2 fill");
    do_load(32'h0000_00A4, 20'h00400, 1'b0, "R8 way3 fill");
    do_load(32'h0000_00A0, 20'h00500, 1'b0, "R8 evict way0");
    do_load(32'h0000_00A8, 20'h00200, 1'b1, "R8 way1 kept");
    do_load(32'h0000_00A0, 20'h00100, 1'b0, "R8 evicted tag misses");
    do_load(32'h0000_00BC, 20'h00300, 1'b1, "R8 way2 kept");
    do_load(32'h0000_00A0, 20'h00400, 1'b1, "R8 way3 kept");
    do_load(32'h0000_00A0, 20'h00500, 1'b1, "R8 new tag present");
    do_load(32'h0000_00A0, 20'h00100, 1'b1, "R8 refilled tag present");
    do_load(32'h0000_00A0, 20'h00200, 1'b0, "R8 pointer advanced to way1");

    // R9: reset during traffic clears the lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready in mid-run reset", 64'(req_ready), 64'd1);
    check(miss_req_valid == 1'b0, "R9 miss idle in mid-run reset", 64'(miss_req_valid), 64'd0);
    rst_n = 1'b1;
    do_load(32'h0000_1040, 20'h12345, 1'b0, "R9 line gone after reset");
    do_load(32'h0000_00A0, 20'h00500, 1'b0, "R9 set 5 gone after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule